// File: doc/BRIEF.md
# Fixed-Latency Load Return Buffer

This block sits between a memory port whose load latency varies and a pipeline whose schedule assumes one constant load-to-use distance. Software programs that distance in a latency register. Every load the pipeline issues is given a buffer entry, and the entry index is the tag that goes out with the memory request. The block then returns the load's data on its writeback port exactly the programmed number of cycles after the load was accepted. This holds whenever memory answers in time.

A response that comes back early is parked in its entry until the load's due cycle. A response that is still missing when the load falls due raises `stall`. The countdowns of every outstanding load freeze until the response appears. The response is then forwarded straight to writeback in the cycle it arrives. Memory may answer in any order, because responses find their entry by tag. A second stall cause holds back an issue request while all entries are busy. This stall does not freeze the countdowns, so the buffer keeps draining.

Top module: `fixlat_load_buffer`

## Requirements
- R1: After reset, `stall` and `wb_valid` are low, every entry is free, and the programmed latency is 4 cycles.
- R2: A load accepted in cycle t (`issue_valid` high and `stall` low) whose response arrives no later than cycle t+N, where N is the latency in force at t, appears on `wb_valid`/`wb_tag`/`wb_data` in cycle t+N and in no earlier cycle.
- R3: If a load's response has not arrived by its due cycle, `stall` is high from that cycle up to the cycle before the response arrives. In the arrival cycle, `wb_valid` is high with that response's data and `stall` is low.
- R4: While `stall` is high because data is late, the countdowns of all other outstanding loads are frozen. Each of those loads is delivered later by exactly the number of late-stall cycles.
- R5: At most 8 loads are outstanding. While all 8 entries are busy, `issue_valid` drives `stall` high and the load is not accepted.
- R6: An accepted load receives on `issue_tag` the lowest-numbered free entry. A response carrying that tag is matched to that load whatever order responses arrive in.
- R7: A write on `lat_wr_en` sets the latency for loads accepted in later cycles only. A load accepted in the write cycle uses the previous value. A written value of 0 is stored as 1.
- R8: At most one load is written back per cycle, and loads leave in issue order. Loads issued in back-to-back cycles with the same latency are written back in back-to-back cycles. A load issued after the latency is lowered is written back one cycle after the load issued before it, if its own latency would otherwise make it due earlier.
- R9: A response whose tag names a free entry, or an entry already holding data, is ignored. It neither changes the data later written back nor produces a writeback.
- R10: A stall caused only by a full buffer leaves countdowns running, so the oldest load is still written back in its own due cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_wr_en | input | 1 | Write strobe for the latency register |
| lat_wr_data | input | 5 | New load-to-use latency in cycles |
| issue_valid | input | 1 | Pipeline issues a load this cycle |
| issue_tag | output | 3 | Entry given to the load accepted this cycle |
| rsp_valid | input | 1 | Memory returns data this cycle |
| rsp_tag | input | 3 | Entry the returning data belongs to |
| rsp_data | input | 32 | Returning load data |
| wb_valid | output | 1 | A load's data is delivered to the pipeline |
| wb_tag | output | 3 | Entry of the delivered load |
| wb_data | output | 32 | Delivered load data |
| stall | output | 1 | Freeze request to the pipeline |

## Verification
The case hardest to reach from the ports is a late response for one load while another load is already in flight. This case shows the freeze of the second countdown and the forwarding path together. The stimulus issues two loads back to back, answers the younger one at once, and holds back the older one's answer for three cycles past its due cycle. A second hard case fills all eight entries, answers them in reverse order and keeps an issue request pending against the full buffer. This shows that draining continues on time and that the freed entry is reused. A lowered latency with a load still in flight is driven directly, to expose the ordering push-out.

// File: rtl/fl_pkg.sv
package fl_pkg;

    localparam int FL_DEPTH_DEF   = 8;
    localparam int FL_DATA_W_DEF  = 32;
    localparam int FL_LAT_W_DEF   = 5;
    localparam int FL_LAT_RST_DEF = 4;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_HELD = 2'd2
    } slot_state_e;

endpackage

// File: rtl/fl_sched.sv
module fl_sched #(
    parameter int LAT_W   = fl_pkg::FL_LAT_W_DEF,
    parameter int LAT_RST = fl_pkg::FL_LAT_RST_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lat_wr_en,
    input  logic [LAT_W-1:0] lat_wr_data,
    input  logic             issue_ok,
    input  logic             freeze,
    output logic [LAT_W-1:0] start_cnt
);
    localparam logic [LAT_W-1:0] ONE = LAT_W'(1);

    logic [LAT_W-1:0] lat_q;
    logic [LAT_W-1:0] tail_q;
    logic [LAT_W-1:0] lat_m1;

    // Programmed latency; zero is promoted to one cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= LAT_W'(LAT_RST);
        end else if (lat_wr_en) begin
            lat_q <= (lat_wr_data == '0) ? ONE : lat_wr_data;
        end
    end

    // Countdown of the youngest outstanding load, tracked like a slot.
    always_comb begin
        lat_m1    = lat_q - ONE;
        start_cnt = (tail_q > lat_m1) ? tail_q : lat_m1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
        end else if (issue_ok) begin
            tail_q <= start_cnt;
        end else if (!freeze && tail_q != '0) begin
            tail_q <= tail_q - ONE;
        end
    end

    AST_LAT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        lat_q != '0);                                              // R7

endmodule

// File: rtl/fl_free_pick.sv
module fl_free_pick #(
    parameter int DEPTH = fl_pkg::FL_DEPTH_DEF,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] busy,
    output logic [TAG_W-1:0] pick,
    output logic             full
);
    always_comb begin
        pick = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) pick = TAG_W'(i);
        end
        full = &busy;
    end
endmodule

// File: rtl/fl_slot.sv
module fl_slot #(
    parameter int DATA_W = fl_pkg::FL_DATA_W_DEF,
    parameter int CNT_W  = fl_pkg::FL_LAT_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_en,
    input  logic [CNT_W-1:0]  alloc_cnt,
    input  logic              freeze,
    input  logic              rsp_hit,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic              deliver,
    output logic              busy,
    output logic              due,
    output logic              held,
    output logic [DATA_W-1:0] data
);
    import fl_pkg::*;

    typedef struct packed {
        slot_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] val;
    } slot_t;

    slot_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st  <= SLOT_FREE;
            q.cnt <= '0;
            q.val <= '0;
        end else if (alloc_en) begin
            q.st  <= SLOT_WAIT;
            q.cnt <= alloc_cnt;
        end else begin
            if (deliver) begin
                q.st <= SLOT_FREE;
            end else if (q.st == SLOT_WAIT && rsp_hit) begin
                q.st  <= SLOT_HELD;
                q.val <= rsp_data;
            end
            if (q.st != SLOT_FREE && !freeze && q.cnt != '0) begin
                q.cnt <= q.cnt - CNT_W'(1);
            end
        end
    end

    always_comb begin
        busy = (q.st != SLOT_FREE);
        due  = busy && (q.cnt == '0);
        held = (q.st == SLOT_HELD);
        data = q.val;
    end

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && freeze && !alloc_en) |=> (q.cnt == $past(q.cnt)));    // R4

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (held && !deliver && !alloc_en) |=> (held && q.val == $past(q.val))); // R9

endmodule

// File: rtl/fixlat_load_buffer.sv
module fixlat_load_buffer #(
    parameter int DEPTH   = fl_pkg::FL_DEPTH_DEF,
    parameter int DATA_W  = fl_pkg::FL_DATA_W_DEF,
    parameter int LAT_W   = fl_pkg::FL_LAT_W_DEF,
    parameter int LAT_RST = fl_pkg::FL_LAT_RST_DEF,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lat_wr_en,
    input  logic [LAT_W-1:0]  lat_wr_data,
    input  logic              issue_valid,
    output logic [TAG_W-1:0]  issue_tag,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              wb_valid,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data,
    output logic              stall
);
    logic [DEPTH-1:0]  busy_vec;
    logic [DEPTH-1:0]  due_vec;
    logic [DEPTH-1:0]  held_vec;
    logic [DATA_W-1:0] data_arr [DEPTH];
    logic [TAG_W-1:0]  pick_idx;
    logic              full;
    logic [LAT_W-1:0]  start_cnt;
    logic [TAG_W-1:0]  sel;
    logic              any_due;
    logic              due_wait;
    logic              issue_ok;

    fl_free_pick #(.DEPTH(DEPTH)) u_pick (
        .busy (busy_vec),
        .pick (pick_idx),
        .full (full)
    );

    fl_sched #(.LAT_W(LAT_W), .LAT_RST(LAT_RST)) u_sched (
        .clk         (clk),
        .rst         (rst),
        .lat_wr_en   (lat_wr_en),
        .lat_wr_data (lat_wr_data),
        .issue_ok    (issue_ok),
        .freeze      (due_wait),
        .start_cnt   (start_cnt)
    );

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            fl_slot #(.DATA_W(DATA_W), .CNT_W(LAT_W)) u_slot (
                .clk       (clk),
                .rst       (rst),
                .alloc_en  (issue_ok && pick_idx == TAG_W'(g)),
                .alloc_cnt (start_cnt),
                .freeze    (due_wait),
                .rsp_hit   (rsp_valid && rsp_tag == TAG_W'(g)),
                .rsp_data  (rsp_data),
                .deliver   (wb_valid && sel == TAG_W'(g)),
                .busy      (busy_vec[g]),
                .due       (due_vec[g]),
                .held      (held_vec[g]),
                .data      (data_arr[g])
            );
        end
    endgenerate

    // Select the single due entry and forward late data straight through.
    always_comb begin
        sel = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (due_vec[i]) sel = TAG_W'(i);
        end
        any_due   = |due_vec;
        wb_valid  = any_due && (held_vec[sel] || (rsp_valid && rsp_tag == sel));
        wb_tag    = sel;
        wb_data   = held_vec[sel] ? data_arr[sel] : rsp_data;
        due_wait  = any_due && !wb_valid;
        stall     = due_wait || (issue_valid && full);
        issue_ok  = issue_valid && !stall;
        issue_tag = pick_idx;
    end

    AST_DUE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(due_vec));                                          // R8

    AST_LATE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(due_wait) |-> wb_valid);                               // R3

    AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (rst)
        issue_ok |=> busy_vec[$past(pick_idx)]);                     // R6

endmodule

// File: tb/fixlat_load_buffer_test.sv
module fixlat_load_buffer_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        lat_wr_en;
    logic [4:0]  lat_wr_data;
    logic        issue_valid;
    logic [2:0]  issue_tag;
    logic        rsp_valid;
    logic [2:0]  rsp_tag;
    logic [31:0] rsp_data;
    logic        wb_valid;
    logic [2:0]  wb_tag;
    logic [31:0] wb_data;
    logic        stall;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fixlat_load_buffer uut (
        .clk         (clk),
        .rst         (rst),
        .lat_wr_en   (lat_wr_en),
        .lat_wr_data (lat_wr_data),
        .issue_valid (issue_valid),
        .issue_tag   (issue_tag),
        .rsp_valid   (rsp_valid),
        .rsp_tag     (rsp_tag),
        .rsp_data    (rsp_data),
        .wb_valid    (wb_valid),
        .wb_tag      (wb_tag),
        .wb_data     (wb_data),
        .stall       (stall)
    );

    typedef struct packed {
        logic [4:0]  lat;
        logic [5:0]  rsp;
        logic [31:0] val;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{5'd4,  6'd1, 32'hA000_0001},
        '{5'd4,  6'd4, 32'hA000_0002},
        '{5'd4,  6'd7, 32'hA000_0003},
        '{5'd1,  6'd1, 32'hA000_0004},
        '{5'd1,  6'd3, 32'hA000_0005},
        '{5'd6,  6'd2, 32'hA000_0006},
        '{5'd3,  6'd9, 32'hA000_0007},
        '{5'd12, 6'd5, 32'hA000_0008}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Start a new cycle: step past the edge and clear the pulse inputs.
    task automatic next_cycle();
        @(posedge clk);
        #1;
        lat_wr_en   = 1'b0;
        issue_valid = 1'b0;
        rsp_valid   = 1'b0;
        rsp_tag     = '0;
        rsp_data    = '0;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic set_lat(input logic [4:0] n);
        next_cycle();
        lat_wr_en   = 1'b1;
        lat_wr_data = n;
    endtask

    // One load: issue in cycle 0, answer in cycle d, expect writeback in cycle e.
    task automatic one_load(input int d, input int e, input int stall_from,
                            input logic [31:0] val, input string req);
        logic [2:0] tg;
        bit ok;
        int bad_k;
        next_cycle();
        issue_valid = 1'b1;
        settle();
        tg = issue_tag;
        ok = !stall;
        bad_k = 0;
        for (int k = 1; k <= e + 2; k++) begin
            next_cycle();
            if (k == d) begin
                rsp_valid = 1'b1;
                rsp_tag   = tg;
                rsp_data  = val;
            end
            settle();
            if (wb_valid !== (k == e)) begin ok = 0; if (bad_k == 0) bad_k = k; end
            if (stall !== (k >= stall_from && k < d)) begin ok = 0; if (bad_k == 0) bad_k = k; end
            if (k == e && (wb_data !== val || wb_tag !== tg)) begin ok = 0; if (bad_k == 0) bad_k = k; end
        end
        chk(ok, req, "writeback cycle/data/stall mismatch at cycle", bad_k, e);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [2:0] tg;
        bit ok;
        int cnt;
        rst         = 1'b1;
        lat_wr_en   = 1'b0;
        lat_wr_data = '0;
        issue_valid = 1'b0;
        rsp_valid   = 1'b0;
        rsp_tag     = '0;
        rsp_data    = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        settle();

        // R1: reset state
        chk(stall == 1'b0, "R1", "stall after reset", stall, 0);
        chk(wb_valid == 1'b0, "R1", "wb_valid after reset", wb_valid, 0);
        chk(issue_tag == 3'd0, "R1", "first free entry", issue_tag, 0);
        // R1: default latency of 4 with early data
        one_load(1, 4, 99, 32'h1234_5678, "R1");

        // Table walk: R2 (early/on-time data), R3 (late data)
        for (int v = 0; v < NVEC; v++) begin
            int n, d, e;
            n = int'(VECS[v].lat);
            d = int'(VECS[v].rsp);
            e = (d > n) ? d : n;
            set_lat(VECS[v].lat);
            one_load(d, e, n, VECS[v].val, (d > n) ? "R3" : "R2");
        end

        // R7: load accepted in the write cycle keeps old latency
        set_lat(5'd5);
        one_load(1, 5, 99, 32'h0000_0077, "R7");
        next_cycle();
        lat_wr_en = 1'b1; lat_wr_data = 5'd2; issue_valid = 1'b1;
        settle();
        tg = issue_tag;
        ok = 1;
        for (int k = 1; k <= 7; k++) begin
            next_cycle();
            if (k == 1) begin rsp_valid = 1'b1; rsp_tag = tg; rsp_data = 32'h55; end
            settle();
            if (wb_valid !== (k == 5)) ok = 0;
        end
        chk(ok, "R7", "same-cycle write used new latency", 0, 5);
        one_load(1, 2, 99, 32'h0000_0088, "R7");
        // R7: zero written becomes one cycle
        set_lat(5'd0);
        one_load(1, 1, 99, 32'h0000_0099, "R7");

        // R4: late older load freezes the younger one
        set_lat(5'd4);
        next_cycle(); issue_valid = 1'b1;              // cycle 0, tag 0
        next_cycle(); issue_valid = 1'b1;              // cycle 1, tag 1
        ok = 1;
        for (int k = 2; k <= 10; k++) begin
            next_cycle();
            if (k == 2) begin rsp_valid = 1'b1; rsp_tag = 3'd1; rsp_data = 32'hBBBB; end
            if (k == 7) begin rsp_valid = 1'b1; rsp_tag = 3'd0; rsp_data = 32'hAAAA; end
            settle();
            if (stall !== (k >= 4 && k <= 6)) ok = 0;
            if (wb_valid !== (k == 7 || k == 8)) ok = 0;
            if (k == 7 && (wb_data !== 32'hAAAA || wb_tag !== 3'd0)) ok = 0;
            if (k == 8 && (wb_data !== 32'hBBBB || wb_tag !== 3'd1)) ok = 0;
        end
        chk(ok, "R4", "younger load delayed by late-stall cycles", 0, 8);

        // R5, R6, R10: fill all entries, answer in reverse order
        set_lat(5'd20);
        ok = 1;
        for (int k = 0; k <= 7; k++) begin
            next_cycle(); issue_valid = 1'b1;
            settle();
            if (issue_tag !== 3'(k) || stall) ok = 0;
        end
        chk(ok, "R6", "entries handed out lowest first", 0, 1);
        begin
            bit ok5, ok6, ok10;
            ok5 = 1; ok6 = 1; ok10 = 1;
            for (int k = 8; k <= 45; k++) begin
                next_cycle();
                if (k <= 21) issue_valid = 1'b1;
                if (k >= 9 && k <= 16) begin
                    rsp_valid = 1'b1;
                    rsp_tag   = 3'(16 - k);
                    rsp_data  = 32'(100 + 16 - k);
                end
                if (k == 30) begin rsp_valid = 1'b1; rsp_tag = 3'd0; rsp_data = 32'd555; end
                settle();
                if (k <= 20 && stall !== 1'b1) ok5 = 0;
                if (k == 21 && (stall !== 1'b0 || issue_tag !== 3'd0)) ok5 = 0;
                if (wb_valid !== ((k >= 20 && k <= 27) || k == 41)) ok10 = 0;
                if (k >= 20 && k <= 27 &&
                    (wb_tag !== 3'(k - 20) || wb_data !== 32'(100 + k - 20))) ok6 = 0;
                if (k == 41 && (wb_tag !== 3'd0 || wb_data !== 32'd555)) ok6 = 0;
            end
            chk(ok5, "R5", "full buffer holds issue until entry frees", 0, 1);
            chk(ok6, "R6", "out-of-order responses matched by tag", 0, 1);
            chk(ok10, "R10", "drain on time under full stall", 0, 1);
        end

        // R8: lowered latency pushes the younger load behind the older
        set_lat(5'd6);
        next_cycle(); issue_valid = 1'b1; lat_wr_en = 1'b1; lat_wr_data = 5'd1;
        next_cycle(); issue_valid = 1'b1;
        ok = 1;
        cnt = 0;
        for (int k = 2; k <= 10; k++) begin
            next_cycle();
            if (k == 2) begin rsp_valid = 1'b1; rsp_tag = 3'd0; rsp_data = 32'hC0; end
            if (k == 3) begin rsp_valid = 1'b1; rsp_tag = 3'd1; rsp_data = 32'hC1; end
            settle();
            if (wb_valid) cnt++;
            if (wb_valid !== (k == 6 || k == 7)) ok = 0;
            if (k == 6 && wb_tag !== 3'd0) ok = 0;
            if (k == 7 && (wb_tag !== 3'd1 || wb_data !== 32'hC1)) ok = 0;
        end
        chk(ok, "R8", "push-out after latency decrease", cnt, 2);

        // R9: duplicate and stray responses are ignored
        set_lat(5'd5);
        next_cycle(); issue_valid = 1'b1;
        settle();
        tg = issue_tag;
        ok = 1;
        for (int k = 1; k <= 9; k++) begin
            next_cycle();
            if (k == 1) begin rsp_valid = 1'b1; rsp_tag = tg; rsp_data = 32'd11; end
            if (k == 2) begin rsp_valid = 1'b1; rsp_tag = tg; rsp_data = 32'd22; end
            if (k == 3 || k == 7) begin rsp_valid = 1'b1; rsp_tag = 3'd6; rsp_data = 32'd33; end
            settle();
            if (wb_valid !== (k == 5)) ok = 0;
            if (k == 5 && wb_data !== 32'd11) ok = 0;
        end
        chk(ok, "R9", "held data kept, strays dropped", wb_data, 11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule